// File: doc/BRIEF.md
# Cartridge ROM Bank Switcher

This block sits between an 8-bit CPU bus and a large cartridge ROM. It widens the CPU's 16-bit address into a ROM address of up to 2 MB. The 32 KB stretch of CPU space from 4000h to BFFFh is cut into four windows of 8 KB each. Each window has its own 8-bit page register, and that register supplies the upper ROM address bits whenever the CPU reads inside that window. Space below 4000h and from C000h upward is left to other devices and is never decoded.

The cartridge has no I/O ports. Software selects a page by writing to the ROM space itself. Each window owns a 2 KB trigger block, and a write that lands anywhere in that block stores the data byte as the window's new page. The trigger blocks start at 5000h for the first window, 7000h for the second, 9000h for the third and A000h for the fourth. The block only responds while the external slot-select input is high. Slot decoding, the ROM array and any other cartridge logic sit outside it.

A two-state write-capture machine makes sure that a write strobe held for several clocks loads a page register only once. In state `ST_IDLE` it accepts a write on the first clock edge where `cpu_wr` is high, and transition *accept* takes it to `ST_HOLD`. In `ST_HOLD` no register can change, and transition *release* returns it to `ST_IDLE` on the first edge where `cpu_wr` is low. When `cpu_wr` is low, `ST_IDLE` stays in `ST_IDLE`. When `cpu_wr` stays high, `ST_HOLD` stays in `ST_HOLD`.

Top module: `rom_bank_mapper`

## Requirements
- R1: After reset, the four windows (4000h, 6000h, 8000h, A000h upward) select pages 0, 1, 2 and 3 respectively.
- R2: `rom_cs` is high exactly when `slot_sel` and `cpu_rd` are both high and `cpu_addr` lies in 4000h..BFFFh.
- R3: While `rom_cs` is high, `rom_addr` equals {page of the window holding `cpu_addr`, `cpu_addr[12:0]`}. The window index is `cpu_addr[15:13]` minus 2.
- R4: An accepted write in 5000h..57FFh, 7000h..77FFh or 9000h..97FFh loads `cpu_data` into the page of window 0, 1 or 2 respectively.
- R5: An accepted write in A000h..A7FFh loads `cpu_data` into the page of window 3.
- R6: A write made while `slot_sel` is low changes no page.
- R7: A write outside the four trigger blocks changes no page. This covers the rest of each window and all addresses below 4000h or at C000h and above.
- R8: A write strobe held for several cycles loads only once, with the data and address present at its first rising clock edge. Another write is accepted only after `cpu_wr` has been low at a rising clock edge.
- R9: A page loaded at a rising clock edge is already used by `rom_addr` in the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_sel | input | 1 | Cartridge slot selected by external decoding |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data (page number) |
| cpu_wr | input | 1 | Write strobe, active high |
| cpu_rd | input | 1 | Read strobe, active high |
| rom_addr | output | 21 | Extended ROM address |
| rom_cs | output | 1 | ROM chip select, active high |

## Verification
The embedded properties check the following on every cycle:
- `rom_cs` never rises outside the selected, read-strobed window.
- Pages stay frozen while the slot is deselected, while the machine is in `ST_HOLD`, and while the address is outside 4000h..BFFFh.
- At most one page loads per edge, and it takes the sampled data byte.

Only the bench scenarios can show the remaining behaviours, by comparing against a behavioural model on every clock:
- the reset page pattern;
- the exact boundaries of each 2 KB trigger block;
- the fact that a long strobe keeps its first data byte while later data changes;
- back-to-back writes being accepted once the strobe drops.

// File: rtl/rbm_pkg.sv
package rbm_pkg;

    localparam int CPU_AW   = 16;
    localparam int BANK_W   = 8;
    localparam int OFF_W    = 13;
    localparam int AREA_CNT = 4;
    localparam int AREA_W   = $clog2(AREA_CNT);
    localparam int ROM_AW   = BANK_W + OFF_W;

    // First window starts at this value of addr[15:13]
    localparam logic [2:0] FIRST_WIN = 3'd2;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_HOLD
    } wr_state_t;

    // addr[12:11] of the 2 KB trigger block inside a window
    function automatic logic [1:0] trig_sub(input logic [AREA_W-1:0] area);
        return (area == AREA_W'(AREA_CNT - 1)) ? 2'b00 : 2'b10;
    endfunction

endpackage

// File: rtl/rbm_decode.sv
module rbm_decode
    import rbm_pkg::*;
#(
    parameter int ADDR_W = CPU_AW,
    parameter int AW     = AREA_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win,
    output logic [AW-1:0]     area,
    output logic              trig_hit
);

    localparam int TOP_LSB = ADDR_W - 3;

    logic [2:0] top3;
    logic [2:0] rel;

    always_comb begin
        top3     = addr[ADDR_W-1:TOP_LSB];
        rel      = top3 - FIRST_WIN;
        in_win   = (top3 >= FIRST_WIN) && (top3 <= FIRST_WIN + 3'(AREA_CNT - 1));
        area     = rel[AW-1:0];
        trig_hit = in_win && (addr[TOP_LSB-1:TOP_LSB-2] == trig_sub(rel[AW-1:0]));
    end

endmodule

// File: rtl/rbm_banks.sv
module rbm_banks
    import rbm_pkg::*;
#(
    parameter int NUM = AREA_CNT,
    parameter int BW  = BANK_W,
    parameter int AW  = AREA_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NUM-1:0]  ld_en,
    input  logic [BW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_area,
    output logic [BW-1:0]   bank_sel,
    output logic [NUM*BW-1:0] banks_flat
);

    logic [BW-1:0] bank_q [NUM];

    for (genvar i = 0; i < NUM; i++) begin : g_bank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q[i] <= BW'(i);
            end else if (ld_en[i]) begin
                bank_q[i] <= wr_data;
            end
        end

        assign banks_flat[i*BW +: BW] = bank_q[i];

        AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
            ld_en[i] |=> (bank_q[i] == $past(wr_data))); // R4
    end

    assign bank_sel = bank_q[rd_area];

    AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ld_en)); // R4

endmodule

// File: rtl/rom_bank_mapper.sv
module rom_bank_mapper
    import rbm_pkg::*;
#(
    parameter int ADDR_W = CPU_AW,
    parameter int BW     = BANK_W,
    parameter int OW     = OFF_W,
    parameter int NUM    = AREA_CNT,
    localparam int AW    = $clog2(NUM),
    localparam int RW    = BW + OW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_sel,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BW-1:0]     cpu_data,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    output logic [RW-1:0]     rom_addr,
    output logic              rom_cs
);

    wr_state_t        state_q, state_d;
    logic             in_win;
    logic             trig_hit;
    logic [AW-1:0]    area;
    logic             wr_accept;
    logic [NUM-1:0]   ld_en;
    logic [BW-1:0]    bank_sel;
    logic [NUM*BW-1:0] banks_flat;

    rbm_decode #(.ADDR_W(ADDR_W), .AW(AW)) u_decode (
        .addr     (cpu_addr),
        .in_win   (in_win),
        .area     (area),
        .trig_hit (trig_hit)
    );

    rbm_banks #(.NUM(NUM), .BW(BW), .AW(AW)) u_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_en      (ld_en),
        .wr_data    (cpu_data),
        .rd_area    (area),
        .bank_sel   (bank_sel),
        .banks_flat (banks_flat)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        wr_accept = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_wr) begin
                    state_d   = ST_HOLD;   // accept
                    wr_accept = slot_sel && trig_hit;
                end
            end
            ST_HOLD: begin
                if (!cpu_wr) begin
                    state_d = ST_IDLE;     // release
                end
            end
            default: state_d = ST_IDLE;
        endcase
        ld_en    = wr_accept ? (NUM'(1) << area) : '0;
        rom_cs   = slot_sel && cpu_rd && in_win;
        rom_addr = {bank_sel, cpu_addr[OW-1:0]};
    end

    AST_CS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        rom_cs |-> (slot_sel && cpu_rd && cpu_addr >= 16'h4000 && cpu_addr <= 16'hBFFF)); // R2

    AST_NO_SLOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_sel |=> $stable(banks_flat)); // R6

    AST_OUTSIDE_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b00 || cpu_addr[15:14] == 2'b11) |=> $stable(banks_flat)); // R7

    AST_HOLD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> $stable(banks_flat)); // R8

endmodule

// File: tb/rom_bank_mapper_bench.sv
module rom_bank_mapper_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_sel = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [20:0] rom_addr;
    logic        rom_cs;

    int n_cmp = 0;
    int n_bad = 0;

    bit [7:0] mdl_bank [4];
    bit       mdl_wr_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rom_bank_mapper u_rom_bank_mapper (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_sel (slot_sel),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .cpu_wr   (cpu_wr),
        .cpu_rd   (cpu_rd),
        .rom_addr (rom_addr),
        .rom_cs   (rom_cs)
    );

    function automatic bit m_in_win(input logic [15:0] a);
        return (a >= 16'h4000) && (a <= 16'hBFFF);
    endfunction

    function automatic int m_area(input logic [15:0] a);
        return (int'(a) - 'h4000) / 'h2000;
    endfunction

    function automatic bit m_trig(input logic [15:0] a);
        return (a >= 16'h5000 && a <= 16'h57FF) || (a >= 16'h7000 && a <= 16'h77FF) ||
               (a >= 16'h9000 && a <= 16'h97FF) || (a >= 16'hA000 && a <= 16'hA7FF);
    endfunction

    // One bus cycle: drive, compare, then advance the model at the edge
    task automatic cyc(input bit s, input bit w, input bit r, input logic [15:0] a,
                       input logic [7:0] d, input string tag);
        logic [20:0] exp_addr;
        bit          exp_cs;
        slot_sel = s; cpu_wr = w; cpu_rd = r; cpu_addr = a; cpu_data = d;
        #1;
        exp_cs = s && r && m_in_win(a);
        n_cmp++;
        if (rom_cs !== exp_cs) begin
            n_bad++;
            $display("FAIL %s/R2 addr=%h rom_cs act=%0b exp=%0b", tag, a, rom_cs, exp_cs);
        end
        if (exp_cs) begin
            exp_addr = {mdl_bank[m_area(a)], a[12:0]};
            n_cmp++;
            if (rom_addr !== exp_addr) begin
                n_bad++;
                $display("FAIL %s/R3 addr=%h rom_addr act=%h exp=%h", tag, a, rom_addr, exp_addr);
            end
        end
        @(posedge clk);
        if (w && !mdl_wr_prev && s && m_trig(a)) mdl_bank[m_area(a)] = d;
        mdl_wr_prev = w;
        @(negedge clk);
    endtask

    task automatic rd_all(input string tag);
        cyc(1, 0, 1, 16'h4123, 8'h00, tag);
        cyc(1, 0, 1, 16'h7FFF, 8'h00, tag);
        cyc(1, 0, 1, 16'h8000, 8'h00, tag);
        cyc(1, 0, 1, 16'hBFFF, 8'h00, tag);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        for (int i = 0; i < 4; i++) mdl_bank[i] = 8'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset pages
        rd_all("R1");
        // R2: chip select outside window or without slot/read
        cyc(1, 0, 1, 16'h0000, 8'h00, "R2");
        cyc(1, 0, 1, 16'h3FFF, 8'h00, "R2");
        cyc(1, 0, 1, 16'hC000, 8'h00, "R2");
        cyc(0, 0, 1, 16'h6000, 8'h00, "R2");
        cyc(1, 0, 0, 16'h6000, 8'h00, "R2");
        for (int a = 0; a < 'h10000; a += 'h0400) cyc(1, 0, 1, 16'(a), 8'h00, "R2");

        // R4 / R5: trigger blocks, with R9 read right after
        cyc(1, 1, 0, 16'h5000, 8'h10, "R4"); cyc(1, 0, 1, 16'h4000, 8'h00, "R9");
        cyc(1, 1, 0, 16'h7400, 8'h21, "R4"); cyc(1, 0, 1, 16'h6001, 8'h00, "R9");
        cyc(1, 1, 0, 16'h97FF, 8'h32, "R4"); cyc(1, 0, 1, 16'h9FFF, 8'h00, "R9");
        cyc(1, 1, 0, 16'hA000, 8'hFF, "R5"); cyc(1, 0, 1, 16'hA000, 8'h00, "R9");
        cyc(1, 1, 0, 16'hA7FF, 8'h7E, "R5");
        rd_all("R5");

        // R6: writes with slot deselected
        cyc(0, 1, 0, 16'h5000, 8'h55, "R6"); cyc(0, 0, 0, 16'h5000, 8'h00, "R6");
        cyc(0, 1, 0, 16'hA000, 8'h56, "R6"); cyc(0, 0, 0, 16'hA000, 8'h00, "R6");
        rd_all("R6");

        // R7: writes outside trigger blocks
        begin
            logic [15:0] miss [11] = '{16'h4000, 16'h4FFF, 16'h5800, 16'h6000, 16'h77FF + 16'h1,
                                       16'h8000, 16'h9800, 16'hA800, 16'hB000, 16'h1000, 16'hF000};
            foreach (miss[k]) begin
                cyc(1, 1, 0, miss[k], 8'hA5, "R7");
                cyc(1, 0, 0, miss[k], 8'h00, "R7");
            end
        end
        cyc(1, 1, 0, 16'hC000, 8'hA6, "R7"); cyc(1, 0, 1, 16'hC000, 8'h00, "R7");
        rd_all("R7");

        // R8: long strobe loads once with first data
        cyc(1, 1, 0, 16'h5000, 8'h40, "R8");
        cyc(1, 1, 0, 16'h5000, 8'h41, "R8");
        cyc(1, 1, 1, 16'h5000, 8'h42, "R8");
        cyc(1, 1, 0, 16'h7000, 8'h43, "R8");
        cyc(1, 0, 1, 16'h4000, 8'h00, "R8");
        cyc(1, 0, 1, 16'h6000, 8'h00, "R8");
        // strobe begun outside a trigger, then moved onto one
        cyc(1, 1, 0, 16'h4000, 8'h60, "R8");
        cyc(1, 1, 0, 16'h9000, 8'h61, "R8");
        cyc(1, 0, 1, 16'h8000, 8'h00, "R8");
        // back-to-back writes once the strobe drops
        cyc(1, 1, 0, 16'h7000, 8'h70, "R8");
        cyc(1, 0, 0, 16'h7000, 8'h00, "R8");
        cyc(1, 1, 0, 16'h7000, 8'h71, "R8");
        cyc(1, 0, 1, 16'h6ABC, 8'h00, "R9");
        rd_all("R3");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule